// File: doc/BRIEF.md
# Interrupt Pending Flag Controller With Three Clear Methods

This block keeps the pending state of a group of interrupt sources and folds it into one registered request line for a processor. Each source is cleared in one of three ways.

- **Hardware-cleared flags.** Each is set by a one-cycle event pulse. It drops by itself when the processor acknowledges entry into that source's service routine, provided the global enable and the source's own enable are both on.
- **Compare flags.** Six channel compare flags share one register. They are never cleared by an acknowledge. Software clears them by writing zeros. Writing a one leaves a bit untouched, so one bit can be cleared without a read-modify-write.
- **Transfer-complete flag.** This flag ignores writes. It drops only after a status read that saw it set, followed by a read or write of the data register.

The processor reaches the flags through a simple single-cycle register port with a combinational read path. It acknowledges service entry by presenting a valid strobe with the serviced source number. Source numbers are assigned as follows:

- Hardware flags take numbers 0 to N_HW-1.
- The compare register takes number N_HW.
- The transfer-complete flag takes number N_HW+1.

Each source number is also the index of that source's bit in the enable vector.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A one-cycle pulse on bit i of `hw_evt` sets hardware flag i at the next clock edge; the flag is read at address 0, bit i.
- R2: A valid acknowledge whose `ack_id` equals i clears hardware flag i at the next edge only when `gie` is 1 and `src_en[i]` is 1; otherwise the flag stays set.
- R3: A write to address 0 clears each hardware flag whose write-data bit is 0 and leaves each one whose bit is 1 unchanged.
- R4: The compare flags are not cleared by an acknowledge of source N_HW, so the request output stays asserted after that acknowledge.
- R5: A pulse on `cmp_evt[i]` sets compare flag i, read at address 1, bit i. A write to address 1 clears the bits written 0, keeps the bits written 1, and bits 6 and 7 always read 0.
- R6: The transfer-complete flag is set by `xfer_done` and read at address 2, bit 0. Writes to address 2 have no effect on it.
- R7: The transfer-complete flag clears on a read or write of address 3 only if an earlier read of address 2 found it set. Accesses to other addresses in between keep that arming. A status read that finds the flag clear does not arm it.
- R8: When a set event and a clear of the same flag fall in the same cycle, the flag is 1 afterwards.
- R9: `irq` is a register, updated each cycle to the OR of every flag ANDed with its source enable bit, all ANDed with `gie`. It follows a flag change one cycle after the flag changes.
- R10: After reset all flags, the data register (address 3, read back as written) and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_evt | input | N_HW | Event pulses for the hardware-cleared flags |
| cmp_evt | input | N_CMP | Event pulses for the shared compare flags |
| xfer_done | input | 1 | Transfer-complete event pulse |
| gie | input | 1 | Global interrupt enable |
| src_en | input | N_HW+2 | Per-source enable, indexed by source number |
| ack_vld | input | 1 | Service-entry acknowledge strobe |
| ack_id | input | ID_W | Source number being serviced |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 hardware flags, 1 compare flags, 2 status, 3 data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: six hardware sources, six compare channels and an 8-bit data path. With these values the eight source numbers exactly fill the 3-bit acknowledge field, so the top two numbers (the compare register and the transfer-complete flag) are exercised at the edge of the identifier range. The 8-bit path also leaves bits 6 and 7 of the compare register above the channels, so the bench can check that they read as zero. A vector table walks the set and clear rules for all three flag kinds. Directed runs then cover enable gating of the auto-clear, set-versus-clear collisions, the one-cycle request latency, and a status read that must not arm the sequence clear.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    REG_HW   = 2'd0,
    REG_CMP  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ifc_hw_flags.sv
module ifc_hw_flags #(
  parameter int N    = 6,
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    evt,
  input  logic [N-1:0]    en,
  input  logic            gie,
  input  logic            ack_vld,
  input  logic [ID_W-1:0] ack_id,
  input  logic            wr_stb,
  input  logic [N-1:0]    wdata,
  output logic [N-1:0]    flag
);
  logic [N-1:0] flag_nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic ack_hit;
    logic clr;
    assign ack_hit = ack_vld && (ack_id == ID_W'(i)) && gie && en[i];
    assign clr     = ack_hit || (wr_stb && !wdata[i]);

    always_comb begin
      flag_nxt[i] = flag[i];
      if (clr)    flag_nxt[i] = 1'b0;
      if (evt[i]) flag_nxt[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= flag_nxt[i];
    end

    AST_HW_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld && ack_id == ID_W'(i) && gie && en[i] && !evt[i]) |=> !flag[i]); // R2
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]); // R8
  end
endmodule

// File: rtl/ifc_cmp_flags.sv
module ifc_cmp_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         wr_stb,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flag
);
  logic [N-1:0] clr_mask;
  logic [N-1:0] flag_nxt;

  always_comb begin
    clr_mask = wr_stb ? ~wdata : '0;
    flag_nxt = (flag & ~clr_mask) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= flag_nxt;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_CMP_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(wr_stb && !wdata[i])); // R5
    AST_CMP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]); // R8
  end
endmodule

// File: rtl/ifc_seq_flag.sv
module ifc_seq_flag #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_evt,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          flag,
  output logic [DW-1:0] data_q
);
  logic armed;
  logic armed_nxt;
  logic flag_nxt;
  logic clr;

  assign clr = armed && (data_rd || data_wr);

  always_comb begin
    flag_nxt  = done_evt || (flag && !clr);
    armed_nxt = armed;
    if (stat_rd && flag) armed_nxt = 1'b1;
    if (clr)             armed_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_nxt;
      armed <= armed_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_wr) data_q <= wdata;
  end

  AST_TC_FALL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && (data_rd || data_wr))); // R7
  AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> flag); // R8
endmodule

// File: rtl/ifc_irq_gen.sv
module ifc_irq_gen #(
  parameter int N_HW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gie,
  input  logic [N_HW+1:0] src_en,
  input  logic [N_HW-1:0] hw_flag,
  input  logic            cmp_any,
  input  logic            tc_flag,
  output logic            irq
);
  logic irq_nxt;

  always_comb begin
    irq_nxt = gie && ((|(hw_flag & src_en[N_HW-1:0]))
                      || (cmp_any && src_en[N_HW])
                      || (tc_flag && src_en[N_HW+1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_nxt;
  end

  AST_IRQ_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq); // R9
  AST_IRQ_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_flag == '0 && !cmp_any && !tc_flag) |=> !irq); // R9
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import ifc_pkg::*;
#(
  parameter int  N_HW  = 6,
  parameter int  N_CMP = 6,
  parameter int  DW    = 8,
  localparam int N_SRC = N_HW + 2,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_HW-1:0]  hw_evt,
  input  logic [N_CMP-1:0] cmp_evt,
  input  logic             xfer_done,
  input  logic             gie,
  input  logic [N_SRC-1:0] src_en,
  input  logic             ack_vld,
  input  logic [ID_W-1:0]  ack_id,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [N_HW-1:0]  hw_flag;
  logic [N_CMP-1:0] cmp_flag;
  logic             tc_flag;
  logic [DW-1:0]    data_q;
  logic             wr_hw, wr_cmp, rd_stat, rd_data, wr_data;
  logic [DW-1:0]    hw_ext, cmp_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    wr_hw   = bus_sel &&  bus_we && (bus_addr == REG_HW);
    wr_cmp  = bus_sel &&  bus_we && (bus_addr == REG_CMP);
    rd_stat = bus_sel && !bus_we && (bus_addr == REG_STAT);
    rd_data = bus_sel && !bus_we && (bus_addr == REG_DATA);
    wr_data = bus_sel &&  bus_we && (bus_addr == REG_DATA);
  end

  ifc_hw_flags #(.N(N_HW), .ID_W(ID_W)) u_hw (
    .clk(clk), .rst_n(rst_int_n), .evt(hw_evt), .en(src_en[N_HW-1:0]),
    .gie(gie), .ack_vld(ack_vld), .ack_id(ack_id), .wr_stb(wr_hw),
    .wdata(bus_wdata[N_HW-1:0]), .flag(hw_flag)
  );

  ifc_cmp_flags #(.N(N_CMP)) u_cmp (
    .clk(clk), .rst_n(rst_int_n), .evt(cmp_evt), .wr_stb(wr_cmp),
    .wdata(bus_wdata[N_CMP-1:0]), .flag(cmp_flag)
  );

  ifc_seq_flag #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .done_evt(xfer_done), .stat_rd(rd_stat),
    .data_rd(rd_data), .data_wr(wr_data), .wdata(bus_wdata),
    .flag(tc_flag), .data_q(data_q)
  );

  ifc_irq_gen #(.N_HW(N_HW)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .gie(gie), .src_en(src_en),
    .hw_flag(hw_flag), .cmp_any(|cmp_flag), .tc_flag(tc_flag), .irq(irq)
  );

  always_comb begin
    hw_ext              = '0;
    hw_ext[N_HW-1:0]    = hw_flag;
    cmp_ext             = '0;
    cmp_ext[N_CMP-1:0]  = cmp_flag;
    case (bus_addr)
      REG_HW:   bus_rdata = hw_ext;
      REG_CMP:  bus_rdata = cmp_ext;
      REG_STAT: bus_rdata = {{(DW-1){1'b0}}, tc_flag};
      default:  bus_rdata = data_q;
    endcase
  end

  AST_CMP_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == REG_CMP) |-> (bus_rdata[DW-1:N_CMP] == '0)); // R5
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] hw_evt, cmp_evt;
  logic       xfer_done, gie, ack_vld, bus_sel, bus_we;
  logic [7:0] src_en, bus_wdata, bus_rdata;
  logic [2:0] ack_id;
  logic [1:0] bus_addr;
  logic       irq;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .cmp_evt(cmp_evt),
    .xfer_done(xfer_done), .gie(gie), .src_en(src_en), .ack_vld(ack_vld),
    .ack_id(ack_id), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {tag, op, arg, check address, expected}
  // op: 0 hw evt, 1 cmp evt, 2 write cmp, 3 write hw, 4 ack, 5 xfer done,
  //     6 write status, 7 read hw, 8 write data, 9 read data
  localparam logic [25:0] VEC [16] = '{
    {4'd1, 4'd0, 8'h05, 2'd0, 8'h05},  // R1 events set flags 0 and 2
    {4'd2, 4'd4, 8'h00, 2'd0, 8'h04},  // R2 ack of source 0 auto-clears
    {4'd5, 4'd1, 8'h01, 2'd1, 8'h01},  // R5 channel 0 alone reads 0x01
    {4'd4, 4'd4, 8'h06, 2'd1, 8'h01},  // R4 ack of compare source keeps it
    {4'd5, 4'd1, 8'h22, 2'd1, 8'h23},  // R5 more channels set
    {4'd5, 4'd2, 8'hFE, 2'd1, 8'h22},  // R5 write 0 clears bit 0 only
    {4'd5, 4'd2, 8'hFF, 2'd1, 8'h22},  // R5 write 1 has no effect
    {4'd5, 4'd2, 8'hC0, 2'd1, 8'h00},  // R5 clear all, bits 6/7 read 0
    {4'd6, 4'd5, 8'h00, 2'd2, 8'h01},  // R6 done sets flag (check read arms)
    {4'd6, 4'd6, 8'h00, 2'd2, 8'h01},  // R6 write to status ignored
    {4'd7, 4'd7, 8'h00, 2'd2, 8'h01},  // R7 other read keeps arming
    {4'd7, 4'd8, 8'h5A, 2'd2, 8'h00},  // R7 data write after arm clears
    {4'd7, 4'd5, 8'h00, 2'd0, 8'h04},  // R7 set again, not armed
    {4'd7, 4'd8, 8'h33, 2'd2, 8'h01},  // R7 unarmed data write keeps flag
    {4'd7, 4'd9, 8'h00, 2'd2, 8'h00},  // R7 data read after arm clears
    {4'd3, 4'd3, 8'hFB, 2'd0, 8'h00}   // R3 write 0 clears hw flag 2
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    hw_evt = '0; cmp_evt = '0; xfer_done = 1'b0; ack_vld = 1'b0; ack_id = '0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic cyc(input logic [5:0] hw, input logic [5:0] cm, input logic tc,
                     input logic sel, input logic we, input logic [1:0] ad,
                     input logic [7:0] wd, input logic av, input logic [2:0] aid);
    hw_evt = hw; cmp_evt = cm; xfer_done = tc; bus_sel = sel; bus_we = we;
    bus_addr = ad; bus_wdata = wd; ack_vld = av; ack_id = aid;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(input logic [1:0] ad, input logic [7:0] exp, input string tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ad;
    #5;
    chk(bus_rdata, exp, tag);
    @(negedge clk);
    idle();
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(posedge clk);
    #1;
    chk({7'b0, irq}, {7'b0, exp}, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    gie = 1'b1; src_en = 8'hFF; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk({7'b0, irq}, 8'h00, "R10 irq");
    rd_chk(2'd0, 8'h00, "R10 hw");
    rd_chk(2'd1, 8'h00, "R10 cmp");
    rd_chk(2'd2, 8'h00, "R10 status");
    rd_chk(2'd3, 8'h00, "R10 data");

    for (int k = 0; k < 16; k++) begin
      logic [3:0] op;
      logic [7:0] a;
      op = VEC[k][21:18];
      a  = VEC[k][17:10];
      case (op)
        4'd0: cyc(a[5:0], '0, 0, 0, 0, 2'd0, 8'h00, 0, 3'd0);
        4'd1: cyc('0, a[5:0], 0, 0, 0, 2'd0, 8'h00, 0, 3'd0);
        4'd2: cyc('0, '0, 0, 1, 1, 2'd1, a, 0, 3'd0);
        4'd3: cyc('0, '0, 0, 1, 1, 2'd0, a, 0, 3'd0);
        4'd4: cyc('0, '0, 0, 0, 0, 2'd0, 8'h00, 1, a[2:0]);
        4'd5: cyc('0, '0, 1, 0, 0, 2'd0, 8'h00, 0, 3'd0);
        4'd6: cyc('0, '0, 0, 1, 1, 2'd2, a, 0, 3'd0);
        4'd7: cyc('0, '0, 0, 1, 0, 2'd0, 8'h00, 0, 3'd0);
        4'd8: cyc('0, '0, 0, 1, 1, 2'd3, a, 0, 3'd0);
        default: cyc('0, '0, 0, 1, 0, 2'd3, 8'h00, 0, 3'd0);
      endcase
      rd_chk(VEC[k][9:8], VEC[k][7:0], $sformatf("vec %0d R%0d", k, VEC[k][25:22]));
    end
    rd_chk(2'd3, 8'h33, "R10 data register readback");

    // R2 enable gating of the auto-clear
    cyc(6'h02, '0, 0, 0, 0, 2'd0, 8'h00, 0, 3'd0);
    src_en[1] = 1'b0;
    cyc('0, '0, 0, 0, 0, 2'd0, 8'h00, 1, 3'd1);
    rd_chk(2'd0, 8'h02, "R2 source enable off keeps flag");
    src_en[1] = 1'b1; gie = 1'b0;
    cyc('0, '0, 0, 0, 0, 2'd0, 8'h00, 1, 3'd1);
    rd_chk(2'd0, 8'h02, "R2 global enable off keeps flag");
    gie = 1'b1;
    cyc('0, '0, 0, 0, 0, 2'd0, 8'h00, 1, 3'd1);
    rd_chk(2'd0, 8'h00, "R2 both enables on clears flag");

    // R8 set against clear in the same cycle
    cyc('0, 6'h04, 0, 1, 1, 2'd1, 8'h00, 0, 3'd0);
    rd_chk(2'd1, 8'h04, "R8 compare set beats write 0");
    cyc(6'h08, '0, 0, 0, 0, 2'd0, 8'h00, 1, 3'd3);
    rd_chk(2'd0, 8'h08, "R8 hw set beats ack");
    cyc('0, '0, 0, 1, 1, 2'd1, 8'h00, 0, 3'd0);
    cyc('0, '0, 0, 1, 1, 2'd0, 8'h00, 0, 3'd0);
    rd_chk(2'd0, 8'h00, "R3 hw write 0 clears");

    // R9 request latency and gating
    cyc(6'h01, '0, 0, 0, 0, 2'd0, 8'h00, 0, 3'd0);
    chk({7'b0, irq}, 8'h00, "R9 irq not yet set");
    irq_chk(1'b1, "R9 irq one cycle after flag");
    src_en[0] = 1'b0;
    irq_chk(1'b0, "R9 source enable masks irq");
    src_en[0] = 1'b1; gie = 1'b0;
    irq_chk(1'b0, "R9 global enable masks irq");
    gie = 1'b1;
    irq_chk(1'b1, "R9 irq back on");
    cyc('0, '0, 0, 0, 0, 2'd0, 8'h00, 1, 3'd0);
    irq_chk(1'b0, "R9 irq drops after auto-clear");

    // R4 compare flags keep requesting after acknowledge
    cyc('0, 6'h01, 0, 0, 0, 2'd0, 8'h00, 0, 3'd0);
    irq_chk(1'b1, "R4 irq from compare flag");
    cyc('0, '0, 0, 0, 0, 2'd0, 8'h00, 1, 3'd6);
    irq_chk(1'b1, "R4 irq stays after acknowledge");
    cyc('0, '0, 0, 1, 1, 2'd1, 8'h00, 0, 3'd0);
    irq_chk(1'b0, "R4 irq drops after software clear");

    // R7 status read with flag clear does not arm
    rd_chk(2'd2, 8'h00, "R7 status clear");
    cyc('0, '0, 1, 0, 0, 2'd0, 8'h00, 0, 3'd0);
    cyc('0, '0, 0, 1, 1, 2'd3, 8'h11, 0, 3'd0);
    rd_chk(2'd2, 8'h01, "R7 early status read did not arm");
    cyc('0, '0, 0, 1, 0, 2'd3, 8'h00, 0, 3'd0);
    rd_chk(2'd2, 8'h00, "R7 armed data read clears");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule